// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Sequencer

The block reads words from a memory that is split into an even bank and an odd bank. Each bank has its own row counter. A start command latches a word address. A chip select must be low and the address strobe high in the same cycle to form a start command. Bit 0 of the address picks the bank that supplies the first word. Bits above bit 0 give the starting row. When the start is odd, the even counter is preloaded one row ahead.

After a start, each read strobe returns the next word in linear address order. The words alternate strictly between the two banks. Each bank's counter steps by one after that bank has delivered a word. Counters wrap at the top of the bank, so a burst has no length limit.

Raising the chip select puts the block in standby, which disables the output. The counters and the next-bank pointer are kept, so lowering the select again with the strobe low resumes the same burst. A write port loads either bank for test.

Each bank holds 2^ROW_W words. The default ROW_W is 8 so that elaboration stays small. A full-size instance with 32K words per bank sets ROW_W to 15.

Top module: `ilv_burst_reader`

## Requirements
- R1: While reset is low, and after it until the first read, `dout_oe` is 0 and `dout` is 0.
- R2: After a start command with `addr[0]`=0 at address A, the n-th following read returns the word stored at linear address A+n-1.
- R3: After a start command with `addr[0]`=1 at address A, the reads return linear addresses A, A+1, A+2 and so on, in order. The first word comes from the odd bank and the second from the even bank at row A[ADDR_W-1:1]+1.
- R4: Read data appears on `dout` on the clock edge that samples the read strobe. `dout_oe` is 1 only while `sel_n` is 0 and a read has completed since the last start command or standby.
- R5: Linear addresses wrap modulo 2^(ROW_W+1): address 2^(ROW_W+1)-1 is followed by address 0.
- R6: While `sel_n` is 1, `dout_oe` is 0, read strobes are ignored and both counters and the pointer hold. Lowering `sel_n` with the address strobe at 0 resumes the burst at the next unread address.
- R7: A start command during a burst abandons it, and the next read returns the new address. A start takes priority over a read strobe in the same cycle.
- R8: A cycle with `sel_n` at 0 and both strobes at 0 does not advance the burst and leaves `dout` unchanged.
- R9: The write port stores `wr_data` on a clock edge with `wr_en` at 1. `wr_addr[0]` selects the odd bank (1) or the even bank (0), and `wr_addr[ADDR_W-1:1]` selects the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select; 1 puts the block in standby |
| addr_strobe | input | 1 | Active-high address latch; starts a new burst |
| rd_strobe | input | 1 | Read strobe; each sampled 1 delivers one word |
| addr | input | ROW_W+1 | Start word address |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Output enable for `dout` |
| wr_en | input | 1 | Test write enable |
| wr_addr | input | ROW_W+1 | Test write word address (bit 0 selects the bank) |
| wr_data | input | DATA_W | Test write data |

## Verification
Every word of both banks is loaded with a value unique to its address. The bench compares each read against a flat linear memory, so any bank swap or counter slip shows up as a value mismatch.

- **Even and odd starts:** bursts begin at both even and odd addresses. These runs separate the two counter preload rules.
- **Wrap:** a burst begins near the top of the address space, which exposes counter wrap errors.
- **Standby and idle cycles:** a burst is broken by standby with the read strobe held high, and by idle gaps. These runs separate a correct hold from a spurious step.
- **Restarts and overwrites:** a burst is interrupted by a new start, including one with the read strobe also high, and a word is rewritten through the test port.
- **Random stimulus:** a final random phase mixes all of the above.

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader #(
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = ROW_W + 1,
  localparam int ROWS   = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              addr_strobe,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] even_mem [ROWS];
  logic [DATA_W-1:0] odd_mem  [ROWS];

  logic [ROW_W-1:0] even_row, odd_row;
  logic             next_odd, have_data;

  wire              start    = !sel_n && addr_strobe;
  wire              step     = !sel_n && !addr_strobe && rd_strobe;
  wire [ROW_W-1:0]  base_row = addr[ADDR_W-1:1];
  wire [ROW_W-1:0]  wr_row   = wr_addr[ADDR_W-1:1];

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr[0])  odd_mem[wr_row]  <= wr_data;
    if (wr_en && !wr_addr[0]) even_mem[wr_row] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_row  <= '0;
      odd_row   <= '0;
      next_odd  <= 1'b0;
      have_data <= 1'b0;
      dout      <= '0;
    end else if (start) begin
      odd_row   <= base_row;
      even_row  <= base_row + ROW_W'(addr[0]);
      next_odd  <= addr[0];
      have_data <= 1'b0;
    end else if (step) begin
      if (next_odd) begin
        dout    <= odd_mem[odd_row];
        odd_row <= odd_row + 1'b1;
      end else begin
        dout     <= even_mem[even_row];
        even_row <= even_row + 1'b1;
      end
      next_odd  <= !next_odd;
      have_data <= 1'b1;
    end else if (sel_n) begin
      have_data <= 1'b0;
    end
  end

  assign dout_oe = have_data && !sel_n;

endmodule

module ilv_burst_reader_chk #(
  parameter int ROW_W = 8,
  localparam int ADDR_W = ROW_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              addr_strobe,
  input logic              rd_strobe,
  input logic [ADDR_W-1:0] addr,
  input logic              dout_oe,
  input logic              next_odd,
  input logic [ROW_W-1:0]  even_row,
  input logic [ROW_W-1:0]  odd_row
);

  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !sel_n); // R4

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !addr_strobe && rd_strobe) ##1 !sel_n |-> dout_oe); // R4

  AST_EVEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && addr_strobe && !addr[0]) |=> (even_row == odd_row) && !next_odd); // R2

  AST_ODD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && addr_strobe && addr[0]) |=> (even_row == odd_row + 1'b1) && next_odd); // R3

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(next_odd) && $stable(even_row) && $stable(odd_row)); // R6

  AST_READ_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !addr_strobe && rd_strobe) |=> next_odd != $past(next_odd)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !addr_strobe && !rd_strobe) |=> $stable(next_odd) && $stable(even_row) && $stable(odd_row)); // R8

endmodule

bind ilv_burst_reader ilv_burst_reader_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr_strobe(addr_strobe),
  .rd_strobe(rd_strobe), .addr(addr), .dout_oe(dout_oe),
  .next_odd(next_odd), .even_row(even_row), .odd_row(odd_row)
);

// File: tb/tb_ilv_burst_reader.sv
module tb_ilv_burst_reader;
  localparam int ROW_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = ROW_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, addr_strobe = 1'b0, rd_strobe = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0, wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] dout;
  logic dout_oe;

  always #2.5 clk = ~clk;

  ilv_burst_reader #(.ROW_W(ROW_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr_strobe(addr_strobe),
    .rd_strobe(rd_strobe), .addr(addr), .dout(dout), .dout_oe(dout_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [DATA_W-1:0] ref_mem [DEPTH];
  int ref_nxt = 0;
  bit ref_have = 1'b0;
  logic [DATA_W-1:0] ref_dout = '0;

  function automatic logic [DATA_W-1:0] pattern(int a);
    return DATA_W'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic compare();
    logic exp_oe;
    exp_oe = ref_have && !sel_n;
    checks++;
    if (dout_oe !== exp_oe || dout !== ref_dout) begin
      errors++;
      $display("FAIL %s dout=%h oe=%b expected dout=%h oe=%b",
               cur_req, dout, dout_oe, ref_dout, exp_oe);
    end
  endtask

  task automatic cyc(input logic s_n, input logic stb, input logic rd, input int a,
                     input logic we = 1'b0, input int wa = 0, input int wd = 0);
    sel_n = s_n; addr_strobe = stb; rd_strobe = rd; addr = ADDR_W'(a);
    wr_en = we; wr_addr = ADDR_W'(wa); wr_data = DATA_W'(wd);
    @(posedge clk);
    if (!s_n && stb) begin
      ref_nxt = a; ref_have = 1'b0;
    end else if (!s_n && rd) begin
      ref_dout = ref_mem[ref_nxt]; ref_nxt = (ref_nxt + 1) % DEPTH; ref_have = 1'b1;
    end else if (s_n) begin
      ref_have = 1'b0;
    end
    if (we) ref_mem[wa] = DATA_W'(wd);
    @(negedge clk);
    compare();
  endtask

  task automatic burst(input int a, input int n);
    cyc(1'b0, 1'b1, 1'b0, a);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b0, 0, 1'b1, i, int'(pattern(i)));

    cur_req = "R4";
    cyc(1'b0, 1'b1, 1'b0, 20);
    cyc(1'b0, 1'b0, 1'b0, 0);

    cur_req = "R2";
    burst(10, 7);
    burst(0, 5);

    cur_req = "R3";
    burst(7, 7);
    burst(DEPTH - 3, 2);

    cur_req = "R5";
    burst(DEPTH - 3, 6);
    burst(DEPTH - 1, 3);

    cur_req = "R8";
    burst(33, 2);
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 0);
    cyc(1'b0, 1'b0, 1'b1, 0);
    cyc(1'b0, 1'b0, 1'b0, 0);
    cyc(1'b0, 1'b0, 1'b1, 0);

    cur_req = "R6";
    burst(50, 3);
    repeat (4) cyc(1'b1, 1'b0, 1'b1, 0);
    cyc(1'b1, 1'b1, 1'b1, 99);
    cyc(1'b0, 1'b0, 1'b0, 0);
    repeat (4) cyc(1'b0, 1'b0, 1'b1, 0);

    cur_req = "R7";
    burst(100, 3);
    cyc(1'b0, 1'b1, 1'b1, 201);
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 0);
    cyc(1'b0, 1'b1, 1'b0, 64);
    repeat (2) cyc(1'b0, 1'b0, 1'b1, 0);

    cur_req = "R9";
    cyc(1'b1, 1'b0, 1'b0, 0, 1'b1, 77, 16'hBEEF);
    cyc(1'b1, 1'b0, 1'b0, 0, 1'b1, 78, 16'h1234);
    burst(77, 3);

    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 8)       cyc(1'b0, 1'b1, $urandom % 2 == 0, int'($urandom % DEPTH));
      else if (r < 15) cyc(1'b1, $urandom % 2 == 0, $urandom % 2 == 0, int'($urandom % DEPTH));
      else if (r < 25) cyc(1'b0, 1'b0, 1'b0, 0, $urandom % 2 == 0,
                           int'($urandom % DEPTH), int'($urandom % 65536));
      else             cyc(1'b0, 1'b0, 1'b1, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule